// File: doc/BRIEF.md
# Descriptor-Ring Serial Channel Controller

This block connects a byte-wide serial stream to memory buffers. It uses two rings of 8-byte buffer descriptors, one for receive and one for transmit, and keeps them in a shared parameter RAM. The block reaches that RAM through a 16-bit synchronous port. It moves payload bytes through a second, byte-wide synchronous data-memory port. Both memory ports have one cycle of read latency: read data is valid in the cycle after the cycle in which `en` is high and `we` is low. Software controls the channel through three small registers: a mode register holding the receive and transmit enables, an event register whose bits are cleared by writing one, and a mask register that permits reception.

Received bytes arrive on a valid/ready stream. A transfer happens on every rising clock edge where `rx_valid` and `rx_ready` are both high. `rx_ready` is high only while the receive engine is idle and reception is permitted, so the sender must hold its byte until accepted. Each received byte fills and closes one whole descriptor. Reception then stays blocked until software clears the receive event.

Transmit bytes leave on a second valid/ready stream. After `tx_valid` rises, `tx_data` is held stable until the edge where `tx_ready` is high. The next payload byte is fetched only after that handshake.

A descriptor holds four big-endian 16-bit words: status at +0, length at +2, the upper buffer-address half at +4 and the lower half at +6. The status word uses bit 15 to mean empty on receive and ready on transmit. Bit 13 of the status word is the wrap flag.

Top module: `rsc_ring_ctrl`

## Requirements
- R1: After reset, `rx_ready`, `tx_valid`, `irq_req`, `evt_o` and `irq_src` are all zero.
- R2: `rx_ready` is high only when all three hold: mode bit 5 is set, event bit 0 is clear, and mask bit 0 is set.
- R3: For each received byte, the block reads the receive table base from parameter-RAM byte address 0x8000. It writes the byte to the 32-bit buffer address taken from descriptor words +4 (upper half) and +6 (lower half). It writes 1 to the length word at +2. It rewrites the status word at +0 with bit 15 cleared and every other bit unchanged.
- R4: Completing a received descriptor sets event bit 0. Reception stays blocked until a register write to the event register (select 1) with data bit 0 equal to 1. Writing 0 to that bit has no effect.
- R5: In both rings, the ring offset returns to 0 after a descriptor whose status bit 13 is set. Otherwise it advances by 8.
- R6: When `irq_allow` is high as a receive descriptor completes, `irq_req` pulses for one cycle and `irq_src` takes the value `IRQ_SRC_CODE`. When `irq_allow` is low, no pulse occurs, but event bit 0 is still set.
- R7: While mode bit 4 is set, the transmit engine reads the table base from parameter-RAM byte address 0x8002. When the current descriptor's status bit 15 is set, the engine sends the number of bytes given in the length word, in address order starting at the buffer address. It then rewrites the status word with bit 15 cleared.
- R8: A transmit descriptor whose status bit 15 is clear causes no output byte. The engine keeps polling that same descriptor.
- R9: While `tx_valid` is high and `tx_ready` is low, `tx_valid` stays high and `tx_data` stays stable.
- R10: A ready transmit descriptor with length 0 is closed (bit 15 cleared) and the ring advances, without any byte being sent.
- R11: While a ring's enable bit (mode bit 5 for receive, mode bit 4 for transmit) is clear, that ring's offset is held at 0.
- R12: Register select 0 writes the mode register. Select 1 clears event bits where the written data has ones. Select 2 writes the mask register. A hardware event set wins over a clear in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 mode, 1 event, 2 mask |
| cfg_wdata | input | 16 | Register write data |
| evt_o | output | 16 | Event register contents |
| rx_valid | input | 1 | Receive byte valid |
| rx_data | input | 8 | Receive byte |
| rx_ready | output | 1 | Receive byte accepted on this edge if valid |
| tx_valid | output | 1 | Transmit byte valid |
| tx_data | output | 8 | Transmit byte |
| tx_ready | input | 1 | Downstream accepts transmit byte |
| pr_en | output | 1 | Parameter-RAM access enable |
| pr_we | output | 1 | Parameter-RAM write |
| pr_addr | output | 16 | Parameter-RAM byte address (even) |
| pr_wdata | output | 16 | Parameter-RAM write data |
| pr_rdata | input | 16 | Parameter-RAM read data, one cycle after a read |
| dm_en | output | 1 | Data-memory access enable |
| dm_we | output | 1 | Data-memory write |
| dm_addr | output | 32 | Data-memory byte address |
| dm_wdata | output | 8 | Data-memory write byte |
| dm_rdata | input | 8 | Data-memory read byte, one cycle after a read |
| irq_allow | input | 1 | Interrupt controller permits the receive interrupt |
| irq_req | output | 1 | One-cycle receive interrupt request |
| irq_src | output | IRQ_SRC_W | Interrupt source code of the last raised request |

## Verification
Some behaviours are checked by assertions on every cycle:
- `rx_ready` is never high unless the mode, event and mask bits permit reception.
- A stalled transmit byte stays valid and unchanged.
- Every interrupt pulse follows a permitted completion, carries the source code, and coincides with a set event bit.

Other behaviours depend on memory contents and ring position, so only the bench's directed scenarios can show them:
- the exact buffer addresses written
- the rewritten length and status words
- wrap against advance
- index reset on disable
- polling of a descriptor that is not ready
- closing of zero-length descriptors

// File: rtl/rsc_pkg.sv
package rsc_pkg;
  localparam int PR_AW     = 16;
  localparam int PR_DW     = 16;
  localparam int BUF_AW    = 32;
  localparam int BYTE_W    = 8;
  localparam int DESC_STEP = 8;
  localparam int OFS_STAT  = 0;
  localparam int OFS_LEN   = 2;
  localparam int OFS_AHI   = 4;
  localparam int OFS_ALO   = 6;
  localparam int BIT_BUSY  = 15;
  localparam int BIT_WRAP  = 13;
  localparam int MODE_RX_BIT = 5;
  localparam int MODE_TX_BIT = 4;
  localparam int EVT_RX_BIT  = 0;
  localparam int MASK_RX_BIT = 0;
  localparam logic [1:0] SEL_MODE = 2'd0;
  localparam logic [1:0] SEL_EVT  = 2'd1;
  localparam logic [1:0] SEL_MASK = 2'd2;

  typedef enum logic [3:0] {
    RX_IDLE, RX_PTR, RX_PTR_W, RX_AHI, RX_AHI_W, RX_ALO, RX_ALO_W,
    RX_STAT, RX_STAT_W, RX_DATA, RX_LEN, RX_STW, RX_FIN
  } rx_state_e;

  typedef enum logic [3:0] {
    TX_IDLE, TX_PTR, TX_PTR_W, TX_STAT, TX_STAT_W, TX_LEN, TX_LEN_W, TX_AHI,
    TX_AHI_W, TX_ALO, TX_ALO_W, TX_BRD, TX_BRD_W, TX_SEND, TX_CLR, TX_FIN
  } tx_state_e;
endpackage

// File: rtl/rsc_regs.sv
module rsc_regs
  import rsc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [1:0]       cfg_sel,
  input  logic [PR_DW-1:0] cfg_wdata,
  input  logic             rx_evt_set,
  output logic [PR_DW-1:0] mode_q,
  output logic [PR_DW-1:0] evt_q,
  output logic [PR_DW-1:0] mask_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
      evt_q  <= '0;
      mask_q <= '0;
    end else begin
      if (cfg_wr && cfg_sel == SEL_MODE) mode_q <= cfg_wdata;
      if (cfg_wr && cfg_sel == SEL_MASK) mask_q <= cfg_wdata;
      if (cfg_wr && cfg_sel == SEL_EVT)  evt_q  <= evt_q & ~cfg_wdata;
      if (rx_evt_set) evt_q[EVT_RX_BIT] <= 1'b1;
    end
  end
endmodule

// File: rtl/rsc_arb2.sv
module rsc_arb2 #(
  parameter int W = 8
) (
  input  logic         req0,
  input  logic [W-1:0] pay0,
  input  logic         req1,
  input  logic [W-1:0] pay1,
  output logic         gnt0,
  output logic         gnt1,
  output logic         req,
  output logic [W-1:0] pay
);
  always_comb begin
    gnt0 = req0;
    gnt1 = req1 && !req0;
    req  = req0 || req1;
    pay  = req0 ? pay0 : pay1;
  end
endmodule

// File: rtl/rsc_rx_engine.sv
module rsc_rx_engine
  import rsc_pkg::*;
#(
  parameter logic [PR_AW-1:0] PTR_LOC = 16'h8000,
  parameter int               SRC_W   = 8,
  parameter logic [SRC_W-1:0] SRC_CODE = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              run,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_data,
  output logic              rx_ready,
  output logic              pr_req,
  output logic              pr_we,
  output logic [PR_AW-1:0]  pr_addr,
  output logic [PR_DW-1:0]  pr_wdata,
  input  logic              pr_gnt,
  input  logic [PR_DW-1:0]  pr_rdata,
  output logic              dm_req,
  output logic [BUF_AW-1:0] dm_addr,
  output logic [BYTE_W-1:0] dm_wdata,
  input  logic              dm_gnt,
  input  logic              irq_allow,
  output logic              evt_set,
  output logic              irq_req,
  output logic [SRC_W-1:0]  irq_src
);
  rx_state_e         st;
  logic [PR_AW-1:0]  idx_q, base_q, desc;
  logic [PR_DW-1:0]  stat_q;
  logic [BUF_AW-1:0] badr_q;
  logic [BYTE_W-1:0] byte_q;

  assign desc = base_q + idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= RX_IDLE; idx_q <= '0; base_q <= '0; stat_q <= '0;
      badr_q <= '0; byte_q <= '0; irq_req <= 1'b0; irq_src <= '0;
    end else begin
      irq_req <= 1'b0;
      unique case (st)
        RX_IDLE:   if (run && rx_valid) begin byte_q <= rx_data; st <= RX_PTR; end
        RX_PTR:    if (pr_gnt) st <= RX_PTR_W;
        RX_PTR_W:  begin base_q <= pr_rdata; st <= RX_AHI; end
        RX_AHI:    if (pr_gnt) st <= RX_AHI_W;
        RX_AHI_W:  begin badr_q[BUF_AW-1:PR_DW] <= pr_rdata; st <= RX_ALO; end
        RX_ALO:    if (pr_gnt) st <= RX_ALO_W;
        RX_ALO_W:  begin badr_q[PR_DW-1:0] <= pr_rdata; st <= RX_STAT; end
        RX_STAT:   if (pr_gnt) st <= RX_STAT_W;
        RX_STAT_W: begin stat_q <= pr_rdata; st <= RX_DATA; end
        RX_DATA:   if (dm_gnt) st <= RX_LEN;
        RX_LEN:    if (pr_gnt) st <= RX_STW;
        RX_STW:    if (pr_gnt) st <= RX_FIN;
        RX_FIN: begin
          if (irq_allow) begin irq_req <= 1'b1; irq_src <= SRC_CODE; end
          idx_q <= stat_q[BIT_WRAP] ? '0 : idx_q + PR_AW'(DESC_STEP);
          st <= RX_IDLE;
        end
        default: st <= RX_IDLE;
      endcase
      if (!en) idx_q <= '0;
    end
  end

  always_comb begin
    rx_ready = (st == RX_IDLE) && run;
    evt_set  = (st == RX_FIN);
    pr_req   = (st == RX_PTR) || (st == RX_AHI) || (st == RX_ALO) ||
               (st == RX_STAT) || (st == RX_LEN) || (st == RX_STW);
    pr_we    = (st == RX_LEN) || (st == RX_STW);
    pr_wdata = '0;
    unique case (st)
      RX_PTR:  pr_addr = PTR_LOC;
      RX_AHI:  pr_addr = desc + PR_AW'(OFS_AHI);
      RX_ALO:  pr_addr = desc + PR_AW'(OFS_ALO);
      RX_LEN:  begin pr_addr = desc + PR_AW'(OFS_LEN); pr_wdata = PR_DW'(1); end
      RX_STW:  begin
        pr_addr  = desc + PR_AW'(OFS_STAT);
        pr_wdata = stat_q & ~(PR_DW'(1) << BIT_BUSY);
      end
      default: pr_addr = desc + PR_AW'(OFS_STAT);
    endcase
    dm_req   = (st == RX_DATA);
    dm_addr  = badr_q;
    dm_wdata = byte_q;
  end
endmodule

// File: rtl/rsc_tx_engine.sv
module rsc_tx_engine
  import rsc_pkg::*;
#(
  parameter logic [PR_AW-1:0] PTR_LOC = 16'h8002
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_data,
  input  logic              tx_ready,
  output logic              pr_req,
  output logic              pr_we,
  output logic [PR_AW-1:0]  pr_addr,
  output logic [PR_DW-1:0]  pr_wdata,
  input  logic              pr_gnt,
  input  logic [PR_DW-1:0]  pr_rdata,
  output logic              dm_req,
  output logic [BUF_AW-1:0] dm_addr,
  input  logic              dm_gnt,
  input  logic [BYTE_W-1:0] dm_rdata
);
  tx_state_e         st;
  logic [PR_AW-1:0]  idx_q, base_q, desc;
  logic [PR_DW-1:0]  stat_q, len_q, cnt_q;
  logic [BUF_AW-1:0] badr_q;
  logic [BYTE_W-1:0] byte_q;

  assign desc = base_q + idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= TX_IDLE; idx_q <= '0; base_q <= '0; stat_q <= '0; len_q <= '0;
      cnt_q <= '0; badr_q <= '0; byte_q <= '0;
    end else begin
      unique case (st)
        TX_IDLE:   if (en) st <= TX_PTR;
        TX_PTR:    if (pr_gnt) st <= TX_PTR_W;
        TX_PTR_W:  begin base_q <= pr_rdata; st <= TX_STAT; end
        TX_STAT:   if (pr_gnt) st <= TX_STAT_W;
        TX_STAT_W: begin
          stat_q <= pr_rdata;
          st <= pr_rdata[BIT_BUSY] ? TX_LEN : TX_IDLE;
        end
        TX_LEN:    if (pr_gnt) st <= TX_LEN_W;
        TX_LEN_W:  begin len_q <= pr_rdata; st <= TX_AHI; end
        TX_AHI:    if (pr_gnt) st <= TX_AHI_W;
        TX_AHI_W:  begin badr_q[BUF_AW-1:PR_DW] <= pr_rdata; st <= TX_ALO; end
        TX_ALO:    if (pr_gnt) st <= TX_ALO_W;
        TX_ALO_W:  begin
          badr_q[PR_DW-1:0] <= pr_rdata;
          cnt_q <= '0;
          st <= (len_q == '0) ? TX_CLR : TX_BRD;
        end
        TX_BRD:    if (dm_gnt) st <= TX_BRD_W;
        TX_BRD_W:  begin byte_q <= dm_rdata; st <= TX_SEND; end
        TX_SEND:   if (tx_ready) begin
          cnt_q <= cnt_q + 1'b1;
          st <= (cnt_q + 1'b1 == len_q) ? TX_CLR : TX_BRD;
        end
        TX_CLR:    if (pr_gnt) st <= TX_FIN;
        TX_FIN:    begin
          idx_q <= stat_q[BIT_WRAP] ? '0 : idx_q + PR_AW'(DESC_STEP);
          st <= TX_IDLE;
        end
        default:   st <= TX_IDLE;
      endcase
      if (!en) idx_q <= '0;
    end
  end

  always_comb begin
    tx_valid = (st == TX_SEND);
    tx_data  = byte_q;
    pr_req   = (st == TX_PTR) || (st == TX_STAT) || (st == TX_LEN) ||
               (st == TX_AHI) || (st == TX_ALO) || (st == TX_CLR);
    pr_we    = (st == TX_CLR);
    pr_wdata = stat_q & ~(PR_DW'(1) << BIT_BUSY);
    unique case (st)
      TX_PTR:  pr_addr = PTR_LOC;
      TX_LEN:  pr_addr = desc + PR_AW'(OFS_LEN);
      TX_AHI:  pr_addr = desc + PR_AW'(OFS_AHI);
      TX_ALO:  pr_addr = desc + PR_AW'(OFS_ALO);
      default: pr_addr = desc + PR_AW'(OFS_STAT);
    endcase
    dm_req  = (st == TX_BRD);
    dm_addr = badr_q + BUF_AW'(cnt_q);
  end
endmodule

// File: rtl/rsc_ring_ctrl.sv
module rsc_ring_ctrl
  import rsc_pkg::*;
#(
  parameter logic [PR_AW-1:0] RX_PTR_LOC   = 16'h8000,
  parameter logic [PR_AW-1:0] TX_PTR_LOC   = 16'h8002,
  parameter int               IRQ_SRC_W    = 8,
  parameter logic [IRQ_SRC_W-1:0] IRQ_SRC_CODE = 8'h28
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_wr,
  input  logic [1:0]           cfg_sel,
  input  logic [PR_DW-1:0]     cfg_wdata,
  output logic [PR_DW-1:0]     evt_o,
  input  logic                 rx_valid,
  input  logic [BYTE_W-1:0]    rx_data,
  output logic                 rx_ready,
  output logic                 tx_valid,
  output logic [BYTE_W-1:0]    tx_data,
  input  logic                 tx_ready,
  output logic                 pr_en,
  output logic                 pr_we,
  output logic [PR_AW-1:0]     pr_addr,
  output logic [PR_DW-1:0]     pr_wdata,
  input  logic [PR_DW-1:0]     pr_rdata,
  output logic                 dm_en,
  output logic                 dm_we,
  output logic [BUF_AW-1:0]    dm_addr,
  output logic [BYTE_W-1:0]    dm_wdata,
  input  logic [BYTE_W-1:0]    dm_rdata,
  input  logic                 irq_allow,
  output logic                 irq_req,
  output logic [IRQ_SRC_W-1:0] irq_src
);
  localparam int PR_PAY = 1 + PR_AW + PR_DW;
  localparam int DM_PAY = 1 + BUF_AW + BYTE_W;

  logic [PR_DW-1:0]  mode_q, evt_q, mask_q;
  logic              rx_evt_set, rx_run;
  logic              rx_pr_req, rx_pr_we, rx_pr_gnt, rx_dm_req, rx_dm_gnt;
  logic [PR_AW-1:0]  rx_pr_addr;
  logic [PR_DW-1:0]  rx_pr_wdata;
  logic [BUF_AW-1:0] rx_dm_addr;
  logic [BYTE_W-1:0] rx_dm_wdata;
  logic              tx_pr_req, tx_pr_we, tx_pr_gnt, tx_dm_req, tx_dm_gnt;
  logic [PR_AW-1:0]  tx_pr_addr;
  logic [PR_DW-1:0]  tx_pr_wdata;
  logic [BUF_AW-1:0] tx_dm_addr;

  rsc_regs u_regs (
    .clk, .rst_n, .cfg_wr, .cfg_sel, .cfg_wdata, .rx_evt_set,
    .mode_q, .evt_q, .mask_q
  );

  assign evt_o  = evt_q;
  assign rx_run = mode_q[MODE_RX_BIT] && !evt_q[EVT_RX_BIT] && mask_q[MASK_RX_BIT];

  rsc_rx_engine #(.PTR_LOC(RX_PTR_LOC), .SRC_W(IRQ_SRC_W), .SRC_CODE(IRQ_SRC_CODE)) u_rx (
    .clk, .rst_n, .en(mode_q[MODE_RX_BIT]), .run(rx_run),
    .rx_valid, .rx_data, .rx_ready,
    .pr_req(rx_pr_req), .pr_we(rx_pr_we), .pr_addr(rx_pr_addr), .pr_wdata(rx_pr_wdata),
    .pr_gnt(rx_pr_gnt), .pr_rdata,
    .dm_req(rx_dm_req), .dm_addr(rx_dm_addr), .dm_wdata(rx_dm_wdata), .dm_gnt(rx_dm_gnt),
    .irq_allow, .evt_set(rx_evt_set), .irq_req, .irq_src
  );

  rsc_tx_engine #(.PTR_LOC(TX_PTR_LOC)) u_tx (
    .clk, .rst_n, .en(mode_q[MODE_TX_BIT]), .tx_valid, .tx_data, .tx_ready,
    .pr_req(tx_pr_req), .pr_we(tx_pr_we), .pr_addr(tx_pr_addr), .pr_wdata(tx_pr_wdata),
    .pr_gnt(tx_pr_gnt), .pr_rdata,
    .dm_req(tx_dm_req), .dm_addr(tx_dm_addr), .dm_gnt(tx_dm_gnt), .dm_rdata
  );

  rsc_arb2 #(.W(PR_PAY)) u_pr_arb (
    .req0(rx_pr_req), .pay0({rx_pr_we, rx_pr_addr, rx_pr_wdata}),
    .req1(tx_pr_req), .pay1({tx_pr_we, tx_pr_addr, tx_pr_wdata}),
    .gnt0(rx_pr_gnt), .gnt1(tx_pr_gnt),
    .req(pr_en), .pay({pr_we, pr_addr, pr_wdata})
  );

  rsc_arb2 #(.W(DM_PAY)) u_dm_arb (
    .req0(rx_dm_req), .pay0({1'b1, rx_dm_addr, rx_dm_wdata}),
    .req1(tx_dm_req), .pay1({1'b0, tx_dm_addr, {BYTE_W{1'b0}}}),
    .gnt0(rx_dm_gnt), .gnt1(tx_dm_gnt),
    .req(dm_en), .pay({dm_we, dm_addr, dm_wdata})
  );
endmodule

// File: rtl/rsc_ring_chk.sv
module rsc_ring_chk #(
  parameter int               SRC_W    = 8,
  parameter logic [SRC_W-1:0] SRC_CODE = '0
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rx_ready,
  input logic             mode_rx,
  input logic             evt_rx,
  input logic             mask_rx,
  input logic             tx_valid,
  input logic             tx_ready,
  input logic [7:0]       tx_data,
  input logic             irq_req,
  input logic             irq_allow,
  input logic [SRC_W-1:0] irq_src
);
  p_rx_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready |-> (mode_rx && !evt_rx && mask_rx));

  p_tx_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  p_irq_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_src == SRC_CODE));

  p_irq_allowed_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> $past(irq_allow));

  p_irq_evt_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> evt_rx);

  p_irq_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |=> !irq_req);
endmodule

bind rsc_ring_ctrl rsc_ring_chk #(.SRC_W(IRQ_SRC_W), .SRC_CODE(IRQ_SRC_CODE)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_ready(rx_ready),
  .mode_rx(mode_q[5]), .evt_rx(evt_q[0]), .mask_rx(mask_q[0]),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
  .irq_req(irq_req), .irq_allow(irq_allow), .irq_src(irq_src)
);

// File: tb/tb_rsc_ring_ctrl.sv
module tb_rsc_ring_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        cfg_wr = 0;
  logic [1:0]  cfg_sel = 0;
  logic [15:0] cfg_wdata = 0;
  logic [15:0] evt_o;
  logic        rx_valid = 0;
  logic [7:0]  rx_data = 0;
  logic        rx_ready, tx_valid, tx_ready = 0;
  logic [7:0]  tx_data;
  logic        pr_en, pr_we, dm_en, dm_we;
  logic [15:0] pr_addr, pr_wdata, pr_rdata;
  logic [31:0] dm_addr;
  logic [7:0]  dm_wdata, dm_rdata;
  logic        irq_allow = 1, irq_req;
  logic [7:0]  irq_src;

  rsc_ring_ctrl dut (.*);

  logic [15:0] pmem [0:32767];
  logic [7:0]  dmem [0:65535];
  logic [31:0] last_waddr = 0;
  int irq_cnt = 0, txv_cnt = 0, tests = 0, fails = 0;

  always @(posedge clk) begin
    if (pr_en) begin
      if (pr_we) pmem[pr_addr[15:1]] <= pr_wdata;
      else pr_rdata <= pmem[pr_addr[15:1]];
    end
    if (dm_en) begin
      if (dm_we) begin dmem[dm_addr[15:0]] <= dm_wdata; last_waddr <= dm_addr; end
      else dm_rdata <= dmem[dm_addr[15:0]];
    end
    if (irq_req) irq_cnt <= irq_cnt + 1;
    if (tx_valid) txv_cnt <= txv_cnt + 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg(input logic [1:0] sel, input logic [15:0] d);
    @(negedge clk); cfg_wr = 1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk); cfg_wr = 0;
  endtask

  task automatic send_rx(input logic [7:0] b);
    int g = 0;
    @(negedge clk); rx_valid = 1; rx_data = b;
    while (!rx_ready && g < 500) begin @(negedge clk); g++; end
    @(negedge clk); rx_valid = 0;
    g = 0;
    while (!evt_o[0] && g < 500) begin @(negedge clk); g++; end
    repeat (2) @(negedge clk);
  endtask

  task automatic take_tx(input int stall, output logic [7:0] b);
    int g = 0;
    logic [7:0] b0;
    while (!tx_valid && g < 2000) begin @(negedge clk); g++; end
    b0 = tx_data;
    repeat (stall) @(negedge clk);
    if (stall > 0) chk("R9 hold", {23'd0, tx_valid, tx_data}, {23'd0, 1'b1, b0});
    tx_ready = 1; @(negedge clk); tx_ready = 0;
    b = b0;
  endtask

  task automatic t_reset;
    chk("R1 rx_ready", {31'd0, rx_ready}, 0);
    chk("R1 tx_valid", {31'd0, tx_valid}, 0);
    chk("R1 irq_req", {31'd0, irq_req}, 0);
    chk("R1 evt", {16'd0, evt_o}, 0);
    chk("R1 irq_src", {24'd0, irq_src}, 0);
  endtask

  task automatic t_gate;
    cfg(2'd2, 16'h0000); cfg(2'd0, 16'h0020);
    @(negedge clk); chk("R2 mask clear blocks", {31'd0, rx_ready}, 0);
    cfg(2'd0, 16'h0000); cfg(2'd2, 16'h0001);
    @(negedge clk); chk("R2 mode clear blocks", {31'd0, rx_ready}, 0);
    cfg(2'd0, 16'h0020);
    @(negedge clk); chk("R12 R2 enabled", {31'd0, rx_ready}, 1);
  endtask

  task automatic t_rx_first;
    int i0 = irq_cnt;
    irq_allow = 1;
    send_rx(8'hA5);
    chk("R3 data", {24'd0, dmem[16'h2000]}, 32'hA5);
    chk("R3 address", last_waddr, 32'h0001_2000);
    chk("R3 length", {16'd0, pmem[16'h0081]}, 1);
    chk("R3 status", {16'd0, pmem[16'h0080]}, 32'h0000);
    chk("R4 event set", {31'd0, evt_o[0]}, 1);
    chk("R6 irq pulse", irq_cnt - i0, 1);
    chk("R6 irq_src", {24'd0, irq_src}, 32'h28);
  endtask

  task automatic t_block;
    repeat (3) @(negedge clk);
    chk("R4 blocked", {31'd0, rx_ready}, 0);
    cfg(2'd1, 16'h0000);
    chk("R4 write0 no effect", {31'd0, evt_o[0]}, 1);
    chk("R4 still blocked", {31'd0, rx_ready}, 0);
    cfg(2'd1, 16'h0001);
    chk("R4 cleared", {31'd0, evt_o[0]}, 0);
    chk("R4 ready again", {31'd0, rx_ready}, 1);
  endtask

  task automatic t_rx_wrap;
    int i0 = irq_cnt;
    irq_allow = 0;
    send_rx(8'h5A);
    chk("R5 second desc data", {24'd0, dmem[16'h2100]}, 32'h5A);
    chk("R3 wrap kept", {16'd0, pmem[16'h0084]}, 32'h2000);
    chk("R6 no irq", irq_cnt - i0, 0);
    chk("R6 event anyway", {31'd0, evt_o[0]}, 1);
    cfg(2'd1, 16'h0001);
    irq_allow = 1;
    send_rx(8'h3C);
    chk("R5 wrapped to first", {24'd0, dmem[16'h2000]}, 32'h3C);
    cfg(2'd1, 16'h0001);
    cfg(2'd0, 16'h0000); cfg(2'd0, 16'h0020);
    send_rx(8'h77);
    chk("R11 rx index reset", {24'd0, dmem[16'h2000]}, 32'h77);
    chk("R11 rx address", last_waddr, 32'h0001_2000);
    cfg(2'd1, 16'h0001);
  endtask

  task automatic t_tx;
    logic [7:0] b;
    int v0;
    cfg(2'd0, 16'h0030);
    v0 = txv_cnt;
    repeat (40) @(negedge clk);
    chk("R8 not ready no output", txv_cnt - v0, 0);
    pmem[16'h0101] = 16'd3; pmem[16'h0102] = 16'h0000; pmem[16'h0103] = 16'h3000;
    pmem[16'h0100] = 16'h8000;
    take_tx(4, b); chk("R7 byte0", {24'd0, b}, 32'h11);
    take_tx(0, b); chk("R7 byte1", {24'd0, b}, 32'h22);
    take_tx(2, b); chk("R7 byte2", {24'd0, b}, 32'h33);
    repeat (40) @(negedge clk);
    chk("R7 status cleared", {16'd0, pmem[16'h0100]}, 0);
    chk("R10 zero length closed", {16'd0, pmem[16'h0104]}, 32'h2000);
    v0 = txv_cnt;
    repeat (20) @(negedge clk);
    chk("R10 no byte", txv_cnt - v0, 0);
    pmem[16'h0101] = 16'd1; pmem[16'h0103] = 16'h3010; pmem[16'h0100] = 16'h8000;
    take_tx(0, b); chk("R5 tx wrapped", {24'd0, b}, 32'h44);
    repeat (30) @(negedge clk);
    cfg(2'd0, 16'h0020);
    repeat (20) @(negedge clk);
    pmem[16'h0103] = 16'h3020; pmem[16'h0100] = 16'h8000;
    pmem[16'h0105] = 16'd1; pmem[16'h0107] = 16'h3030; pmem[16'h0104] = 16'hA000;
    cfg(2'd0, 16'h0030);
    take_tx(0, b); chk("R11 tx index reset", {24'd0, b}, 32'h55);
    take_tx(0, b); chk("R5 tx advance", {24'd0, b}, 32'h66);
  endtask

  initial begin
    for (int i = 0; i < 32768; i++) pmem[i] = 16'h0;
    for (int i = 0; i < 65536; i++) dmem[i] = 8'h0;
    pmem[16'h4000] = 16'h0100; pmem[16'h4001] = 16'h0200;
    pmem[16'h0080] = 16'h8000; pmem[16'h0082] = 16'h0001; pmem[16'h0083] = 16'h2000;
    pmem[16'h0084] = 16'hA000; pmem[16'h0086] = 16'h0001; pmem[16'h0087] = 16'h2100;
    pmem[16'h0104] = 16'hA000;
    dmem[16'h3000] = 8'h11; dmem[16'h3001] = 8'h22; dmem[16'h3002] = 8'h33;
    dmem[16'h3010] = 8'h44; dmem[16'h3020] = 8'h55; dmem[16'h3030] = 8'h66;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_gate;
    t_rx_first;
    t_block;
    t_rx_wrap;
    t_tx;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule